// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit turns a 14-bit virtual address into a physical address using a small set of per-segment registers. The upper two address bits pick one of the segment slots and the lower twelve bits form the offset. Each slot holds a base, a limit and a direction bit. An upward slot places the offset above its base. A downward slot, used for a stack, places the offset below its base. An access that falls outside the slot's limit is reported as a fault and produces no translation.

Requests arrive on a one-cycle strobe. The translation itself is combinational and feeds a registered output stage, so the result appears exactly one cycle after the strobe. The slot registers are written through a configuration port. Only kernel-mode writes take effect. A write attempted in user mode changes nothing and produces a one-cycle privilege-violation pulse.

The output stage is a three-state machine. `OUT_IDLE` means no result is being presented. `OUT_MAPPED` presents a legal translation. `OUT_FAULT` presents a rejected access. On every clock edge the next state is chosen from the current inputs alone: no strobe leads to `OUT_IDLE`, a strobe with a legal access leads to `OUT_MAPPED`, and a strobe with an illegal access leads to `OUT_FAULT`. These transitions apply from any state.

Top module: `seg_xlate`

## Requirements
- R1: While reset is asserted and after it is released, `pa`, `pa_valid`, `pa_fault` and `priv_viol` are 0. Every slot resets to base 0, limit 0 and upward direction.
- R2: For a slot with direction bit 0 (upward), a legal request drives `pa_valid`=1 and `pa` = (base + offset) mod 2^16 exactly one cycle after the strobe.
- R3: For an upward slot, the access is legal only when offset < limit. Otherwise `pa_fault`=1 one cycle after the strobe.
- R4: For a slot with direction bit 1 (downward), let mag = 4096 − offset. The access is legal when mag ≤ limit, and then `pa` = (base − mag) mod 2^16 with `pa_valid`=1 one cycle after the strobe.
- R5: For a downward slot with mag > limit, `pa_fault`=1 one cycle after the strobe.
- R6: Selector value 2 (vaddr[13:12]=2'b10) always faults, even after a configuration write naming slot 2.
- R7: `pa_valid` and `pa_fault` are never both 1. Exactly one of them is 1 in the cycle after a strobe, and neither is 1 in the cycle after a cycle with no strobe.
- R8: A kernel-mode write (`cfg_we`=1, `kernel_mode`=1) updates the slot named by `cfg_sel` at the clock edge. A request strobed in the following cycle uses the new values.
- R9: A write with `kernel_mode`=0 leaves every slot unchanged and raises `priv_viol` for exactly the one cycle after it. `priv_viol` is 0 at all other times.
- R10: `pa` is 0 whenever `pa_valid` is 0.
- R11: Selector 0 (code), 1 (heap) and 3 (stack) use independent registers. Writing one slot does not change the translation of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Translation request strobe |
| vaddr | input | 14 | Virtual address: [13:12] selector, [11:0] offset |
| kernel_mode | input | 1 | High when the current mode is kernel |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Slot to write |
| cfg_base | input | 16 | Base value to load |
| cfg_limit | input | 13 | Limit value to load (0 to 4096) |
| cfg_down | input | 1 | Direction to load: 1 = downward |
| pa | output | 16 | Registered physical address |
| pa_valid | output | 1 | Registered legal-translation flag |
| pa_fault | output | 1 | Registered fault flag |
| priv_viol | output | 1 | Pulse for a rejected user-mode write |

## Verification
Several properties are checked on every cycle. Valid and fault never overlap, and each strobe is followed by exactly one response. No response appears without a strobe. Selector 2 always faults, the address is zero when no valid translation is shown, and the privilege pulse follows only a user-mode write. The arithmetic cannot be covered by those checks and is left to the bench scenarios. These cover the up and down address values, the limit edges on both sides, write-then-use ordering, slot independence, and a rejected write leaving the translation untouched.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
    localparam int SEG_CODE  = 0;
    localparam int SEG_HEAP  = 1;
    localparam int SEG_RSVD  = 2;
    localparam int SEG_STACK = 3;

    typedef enum logic [1:0] {
        OUT_IDLE   = 2'd0,
        OUT_MAPPED = 2'd1,
        OUT_FAULT  = 2'd2
    } out_state_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
    parameter int OFF_W = 12,
    parameter int SEL_W = 2,
    parameter int PA_W  = 16,
    localparam int NSEG = 1 << SEL_W,
    localparam int LIM_W = OFF_W + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic                        kernel_mode,
    input  logic [SEL_W-1:0]            cfg_sel,
    input  logic [PA_W-1:0]             cfg_base,
    input  logic [LIM_W-1:0]            cfg_limit,
    input  logic                        cfg_down,
    output logic [NSEG-1:0][PA_W-1:0]   slot_base,
    output logic [NSEG-1:0][LIM_W-1:0]  slot_limit,
    output logic [NSEG-1:0]             slot_down,
    output logic                        priv_viol
);
    import seg_xlate_pkg::*;

    logic wr_ok;
    assign wr_ok = cfg_we && kernel_mode;

    for (genvar s = 0; s < NSEG; s++) begin : g_slot
        if (s == SEG_RSVD) begin : g_unused
            assign slot_base[s]  = '0;
            assign slot_limit[s] = '0;
            assign slot_down[s]  = 1'b0;
        end else begin : g_live
            logic [PA_W-1:0]  base_q;
            logic [LIM_W-1:0] limit_q;
            logic             down_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    base_q  <= '0;
                    limit_q <= '0;
                    down_q  <= 1'b0;
                end else if (wr_ok && cfg_sel == SEL_W'(s)) begin
                    base_q  <= cfg_base;
                    limit_q <= cfg_limit;
                    down_q  <= cfg_down;
                end
            end
            assign slot_base[s]  = base_q;
            assign slot_limit[s] = limit_q;
            assign slot_down[s]  = down_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) priv_viol <= 1'b0;
        else        priv_viol <= cfg_we && !kernel_mode;
    end
endmodule

// File: rtl/seg_calc.sv
module seg_calc #(
    parameter int OFF_W = 12,
    parameter int SEL_W = 2,
    parameter int PA_W  = 16,
    localparam int NSEG = 1 << SEL_W,
    localparam int LIM_W = OFF_W + 1
) (
    input  logic [SEL_W-1:0]            sel,
    input  logic [OFF_W-1:0]            offset,
    input  logic [NSEG-1:0][PA_W-1:0]   slot_base,
    input  logic [NSEG-1:0][LIM_W-1:0]  slot_limit,
    input  logic [NSEG-1:0]             slot_down,
    output logic [PA_W-1:0]             pa_calc,
    output logic                        legal
);
    import seg_xlate_pkg::*;

    localparam logic [LIM_W-1:0] SPAN = {1'b1, {OFF_W{1'b0}}};

    logic [PA_W-1:0]  base;
    logic [LIM_W-1:0] limit;
    logic [LIM_W-1:0] off_x;
    logic [LIM_W-1:0] mag;

    always_comb begin
        base    = slot_base[sel];
        limit   = slot_limit[sel];
        off_x   = {1'b0, offset};
        mag     = SPAN - off_x;
        if (sel == SEL_W'(SEG_RSVD)) begin
            legal   = 1'b0;
            pa_calc = '0;
        end else if (slot_down[sel]) begin
            legal   = (mag <= limit);
            pa_calc = base - PA_W'(mag);
        end else begin
            legal   = (off_x < limit);
            pa_calc = base + PA_W'(offset);
        end
    end
endmodule

// File: rtl/seg_outstage.sv
module seg_outstage #(
    parameter int PA_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic            legal,
    input  logic [PA_W-1:0] pa_calc,
    output logic [PA_W-1:0] pa,
    output logic            pa_valid,
    output logic            pa_fault
);
    import seg_xlate_pkg::*;

    out_state_e      state_q, state_d;
    logic [PA_W-1:0] pa_q;

    always_comb begin
        if (!req)       state_d = OUT_IDLE;
        else if (legal) state_d = OUT_MAPPED;
        else            state_d = OUT_FAULT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OUT_IDLE;
            pa_q    <= '0;
        end else begin
            state_q <= state_d;
            pa_q    <= (req && legal) ? pa_calc : '0;
        end
    end

    always_comb begin
        pa_valid = 1'b0;
        pa_fault = 1'b0;
        pa       = '0;
        unique case (state_q)
            OUT_IDLE:   ;
            OUT_MAPPED: begin
                pa_valid = 1'b1;
                pa       = pa_q;
            end
            OUT_FAULT:  pa_fault = 1'b1;
            default:    ;
        endcase
    end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
    parameter int OFF_W = 12,
    parameter int SEL_W = 2,
    parameter int PA_W  = 16,
    localparam int VA_W  = SEL_W + OFF_W,
    localparam int NSEG  = 1 << SEL_W,
    localparam int LIM_W = OFF_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [VA_W-1:0]  vaddr,
    input  logic             kernel_mode,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [PA_W-1:0]  cfg_base,
    input  logic [LIM_W-1:0] cfg_limit,
    input  logic             cfg_down,
    output logic [PA_W-1:0]  pa,
    output logic             pa_valid,
    output logic             pa_fault,
    output logic             priv_viol
);
    logic [NSEG-1:0][PA_W-1:0]  slot_base;
    logic [NSEG-1:0][LIM_W-1:0] slot_limit;
    logic [NSEG-1:0]            slot_down;
    logic [PA_W-1:0]            pa_calc;
    logic                       legal;

    seg_regfile #(.OFF_W(OFF_W), .SEL_W(SEL_W), .PA_W(PA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .kernel_mode(kernel_mode),
        .cfg_sel    (cfg_sel),
        .cfg_base   (cfg_base),
        .cfg_limit  (cfg_limit),
        .cfg_down   (cfg_down),
        .slot_base  (slot_base),
        .slot_limit (slot_limit),
        .slot_down  (slot_down),
        .priv_viol  (priv_viol)
    );

    seg_calc #(.OFF_W(OFF_W), .SEL_W(SEL_W), .PA_W(PA_W)) u_calc (
        .sel        (vaddr[VA_W-1:OFF_W]),
        .offset     (vaddr[OFF_W-1:0]),
        .slot_base  (slot_base),
        .slot_limit (slot_limit),
        .slot_down  (slot_down),
        .pa_calc    (pa_calc),
        .legal      (legal)
    );

    seg_outstage #(.PA_W(PA_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .legal    (legal),
        .pa_calc  (pa_calc),
        .pa       (pa),
        .pa_valid (pa_valid),
        .pa_fault (pa_fault)
    );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int OFF_W = 12,
    parameter int SEL_W = 2,
    parameter int PA_W  = 16,
    localparam int VA_W = SEL_W + OFF_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req,
    input logic [VA_W-1:0]  vaddr,
    input logic             kernel_mode,
    input logic             cfg_we,
    input logic [PA_W-1:0]  pa,
    input logic             pa_valid,
    input logic             pa_fault,
    input logic             priv_viol
);
    import seg_xlate_pkg::*;

    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(pa_valid && pa_fault));

    p_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (pa_valid || pa_fault));

    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (!pa_valid && !pa_fault));

    p_rsvd_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && vaddr[VA_W-1:OFF_W] == SEL_W'(SEG_RSVD)) |=> pa_fault);

    p_pa_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pa_valid |-> (pa == '0));

    p_priv_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !kernel_mode) |=> priv_viol);

    p_priv_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && !kernel_mode) |=> !priv_viol);
endmodule

bind seg_xlate seg_xlate_chk #(.OFF_W(OFF_W), .SEL_W(SEL_W), .PA_W(PA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .vaddr      (vaddr),
    .kernel_mode(kernel_mode),
    .cfg_we     (cfg_we),
    .pa         (pa),
    .pa_valid   (pa_valid),
    .pa_fault   (pa_fault),
    .priv_viol  (priv_viol)
);

// File: tb/seg_xlate_bench.sv
`timescale 1ns/1ps
module seg_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [13:0] vaddr = '0;
    logic        kernel_mode = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_base = '0;
    logic [12:0] cfg_limit = '0;
    logic        cfg_down = 1'b0;
    logic [15:0] pa;
    logic        pa_valid, pa_fault, priv_viol;

    always #2 clk = ~clk;

    seg_xlate u_seg_xlate (
        .clk(clk), .rst_n(rst_n), .req(req), .vaddr(vaddr),
        .kernel_mode(kernel_mode), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_down(cfg_down),
        .pa(pa), .pa_valid(pa_valid), .pa_fault(pa_fault), .priv_viol(priv_viol)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [15:0] m_base [4];
    logic [12:0] m_lim  [4];
    logic        m_down [4];

    logic [17:0] exp_q [$];
    string       tag_q [$];

    task automatic check(input bit ok, input string tag, input logic [17:0] act, input logic [17:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual={v%0b f%0b pa=%h} expected={v%0b f%0b pa=%h}",
                     tag, act[17], act[16], act[15:0], exp[17], exp[16], exp[15:0]);
        end
    endtask

    function automatic logic [17:0] model(input logic [13:0] a);
        int sel = int'(a[13:12]);
        int off = int'(a[11:0]);
        int mag;
        if (sel == 2) return {2'b01, 16'h0};
        if (m_down[sel]) begin
            mag = 4096 - off;
            if (mag <= int'(m_lim[sel])) return {2'b10, 16'(m_base[sel] - 16'(mag))};
            return {2'b01, 16'h0};
        end
        if (off < int'(m_lim[sel])) return {2'b10, 16'(m_base[sel] + 16'(off))};
        return {2'b01, 16'h0};
    endfunction

    task automatic do_req(input logic [1:0] sel, input logic [11:0] off, input string tag);
        @(negedge clk);
        req   = 1'b1;
        vaddr = {sel, off};
        exp_q.push_back(model({sel, off}));
        tag_q.push_back(tag);
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic do_cfg(input bit kern, input logic [1:0] sel, input logic [15:0] b,
                          input logic [12:0] l, input bit dn);
        @(negedge clk);
        cfg_we = 1'b1; kernel_mode = kern; cfg_sel = sel;
        cfg_base = b; cfg_limit = l; cfg_down = dn;
        if (kern && sel != 2'd2) begin
            m_base[sel] = b; m_lim[sel] = l; m_down[sel] = dn;
        end
        @(negedge clk);
        cfg_we = 1'b0; kernel_mode = 1'b0;
    endtask

    // monitor: scoreboard pop and privilege pulse check
    always @(posedge clk) begin
        bit r_s, pv_s, rs_s;
        logic [17:0] e;
        string t;
        r_s  = req;
        pv_s = cfg_we && !kernel_mode;
        rs_s = rst_n;
        #1;
        if (rs_s && !done) begin
            if (r_s) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({pa_valid, pa_fault, pa} == e, t, {pa_valid, pa_fault, pa}, e);
            end else begin
                check(!pa_valid && !pa_fault && pa == 0, "R7 idle no response",
                      {pa_valid, pa_fault, pa}, 18'h0);
            end
            check(priv_viol == pv_s, "R9 privilege pulse", {17'h0, priv_viol}, {17'h0, pv_s});
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_base[i] = '0; m_lim[i] = '0; m_down[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        check(pa == 0 && !pa_valid && !pa_fault && !priv_viol, "R1 in reset",
              {pa_valid, pa_fault, pa}, 18'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pa == 0 && !pa_valid && !pa_fault && !priv_viol, "R1 after reset",
              {pa_valid, pa_fault, pa}, 18'h0);
        do_req(2'd0, 12'h000, "R1 reset limit zero faults");

        do_cfg(1, 2'd0, 16'h1000, 13'h0800, 0);
        do_cfg(1, 2'd1, 16'h4000, 13'h1000, 0);
        do_cfg(1, 2'd3, 16'h8000, 13'h0400, 1);
        do_req(2'd0, 12'h010, "R2 code up map");
        do_req(2'd0, 12'h7FF, "R3 last legal up offset");
        do_req(2'd0, 12'h800, "R3 offset equal limit faults");
        do_req(2'd1, 12'h000, "R11 heap slot");
        do_req(2'd1, 12'hFFF, "R2 full-span heap");
        do_req(2'd3, 12'hFFF, "R4 stack mag 1");
        do_req(2'd3, 12'hC00, "R4 stack mag equal limit");
        do_req(2'd3, 12'hBFF, "R5 stack mag over limit");
        do_req(2'd3, 12'h000, "R5 stack mag 4096");
        do_req(2'd2, 12'h000, "R6 reserved selector");
        do_cfg(1, 2'd2, 16'h2222, 13'h1000, 0);
        do_req(2'd2, 12'h004, "R6 reserved after write");
        do_cfg(0, 2'd0, 16'h2000, 13'h1000, 0);
        do_req(2'd0, 12'h010, "R9 user write ignored");
        do_req(2'd0, 12'h900, "R9 user limit ignored");
        do_cfg(1, 2'd0, 16'hFFF0, 13'h0100, 0);
        do_req(2'd0, 12'h020, "R8 new base wraps");
        do_req(2'd3, 12'hF00, "R11 stack untouched");
        do_req(2'd1, 12'h123, "R11 heap untouched");
        do_cfg(1, 2'd1, 16'h0100, 13'h1000, 1);
        do_req(2'd1, 12'h000, "R4 heap turned down mag 4096");

        // back-to-back strobes
        @(negedge clk);
        req = 1'b1; vaddr = {2'd0, 12'h005};
        exp_q.push_back(model(vaddr)); tag_q.push_back("R7 back-to-back first");
        @(negedge clk);
        vaddr = {2'd0, 12'h100};
        exp_q.push_back(model(vaddr)); tag_q.push_back("R7 back-to-back fault");
        @(negedge clk);
        vaddr = {2'd3, 12'hE00};
        exp_q.push_back(model(vaddr)); tag_q.push_back("R7 back-to-back stack");
        @(negedge clk);
        req = 1'b0;
        repeat (3) @(negedge clk);
        done = 1;
        if (exp_q.size() != 0) check(0, "R7 missing responses", 18'(exp_q.size()), 18'h0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        done = 1;
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule